// File: doc/BRIEF.md
# Byte Arithmetic, Logic and Shift Unit with Flags

This block is the execution stage of a small 8-bit core. It combines a source byte with a second byte (a register value or an immediate, already chosen upstream) or shifts the source byte by a 3-bit count. It returns an 8-bit result and the next values of the zero and carry flags. A 2-bit class input tells it whether the operation in flight is an arithmetic/logic one, a shift one, or something else, such as a memory access or a branch, that must leave the flags alone.

The result and next-flag outputs are purely combinational. The top also holds the two flags in registers that load on the rising clock edge when the flag-write output is high. The held carry can be fed back into the carry input, so multi-byte add and subtract chains run one byte per cycle.

Top module: `byte_exec_unit`

## Requirements
- R1: With class 00, function 000 (add) gives result = a + b modulo 256 and next carry = carry out; function 001 (add with carry) also adds the carry input.
- R2: With class 00, function 010 (subtract) gives result = a - b modulo 256 and next carry = 1 exactly when a borrow occurs; function 011 also subtracts the carry input as a borrow in.
- R3: With class 00, functions 100, 101, 110 and 111 give a AND b, a OR b, a XOR b and a AND NOT b respectively, and next carry is 0 whatever the carry input.
- R4: Whenever flag_we is high, next zero is 1 exactly when the 8-bit result is 0.
- R5: With class 01, function bits [1:0] = 00 shift left and 01 shift right by the count, filling with zeros; next carry is the last bit pushed out of the byte.
- R6: With class 01, function bits [1:0] = 10 rotate left and 11 rotate right by the count, wrapping bits to the other end; next carry is the last bit that crossed the byte boundary.
- R7: With class 01 and a count of 0, the result equals the source byte and next carry is 0.
- R8: flag_we is high only for classes 00 and 01. For classes 10 and 11 the result is 0 and the next-flag outputs repeat the held flags.
- R9: Reset clears both held flags. On each rising edge with flag_we high, the held flags take the next-flag values; otherwise they keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held flags |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 2 | 00 arithmetic/logic, 01 shift, 10/11 no flag effect |
| func | input | 3 | Function code within the class |
| src_a | input | 8 | Source byte |
| src_b | input | 8 | Second byte |
| shamt | input | 3 | Shift or rotate count, 0 to 7 |
| c_in | input | 1 | Incoming carry flag |
| result | output | 8 | Operation result |
| z_next | output | 1 | Next zero flag |
| c_next | output | 1 | Next carry flag |
| flag_we | output | 1 | Flag update enable |
| z_q | output | 1 | Held zero flag |
| c_q | output | 1 | Held carry flag |

## Verification
The result, the next flags and flag_we depend only on the present inputs and the held flags, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and reads these outputs one nanosecond later. The held flags are due one rising edge after a cycle with flag_we high. The bench therefore reads them just after that edge, and in the carry-chain test it feeds the held carry into the next byte's operation.

// File: rtl/byte_exec_unit.sv
module byte_exec_unit #(
  parameter int W = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_class,
  input  logic [2:0]    func,
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  src_b,
  input  logic [SW-1:0] shamt,
  input  logic          c_in,
  output logic [W-1:0]  result,
  output logic          z_next,
  output logic          c_next,
  output logic          flag_we,
  output logic          z_q,
  output logic          c_q
);
  localparam int W2 = 2 * W;

  logic [W:0]    sum, dif;
  logic [W2-1:0] shl_w, shr_w, rol_w, ror_w;
  logic [W-1:0]  alu_r, sh_r;
  logic          alu_c, sh_c;

  assign sum = {1'b0, src_a} + {1'b0, src_b} + {{W{1'b0}}, func[0] & c_in};
  assign dif = {1'b0, src_a} - {1'b0, src_b} - {{W{1'b0}}, func[0] & c_in};

  always_comb begin
    alu_c = 1'b0;
    unique case (func)
      3'b000, 3'b001: begin alu_r = sum[W-1:0]; alu_c = sum[W]; end
      3'b010, 3'b011: begin alu_r = dif[W-1:0]; alu_c = dif[W]; end
      3'b100:         alu_r = src_a & src_b;
      3'b101:         alu_r = src_a | src_b;
      3'b110:         alu_r = src_a ^ src_b;
      default:        alu_r = src_a & ~src_b;
    endcase
  end

  assign shl_w = {{W{1'b0}}, src_a} << shamt;
  assign shr_w = {src_a, {W{1'b0}}} >> shamt;
  assign rol_w = {src_a, src_a} << shamt;
  assign ror_w = {src_a, src_a} >> shamt;

  always_comb begin
    unique case (func[1:0])
      2'b00: begin sh_r = shl_w[W-1:0];  sh_c = shl_w[W];   end
      2'b01: begin sh_r = shr_w[W2-1:W]; sh_c = shr_w[W-1]; end
      2'b10: begin sh_r = rol_w[W2-1:W]; sh_c = rol_w[W];   end
      default: begin sh_r = ror_w[W-1:0]; sh_c = ror_w[W-1]; end
    endcase
    if (shamt == '0) sh_c = 1'b0;
  end

  assign flag_we = ~op_class[1];
  assign result  = op_class[1] ? '0 : (op_class[0] ? sh_r : alu_r);
  assign z_next  = flag_we ? (result == '0) : z_q;
  assign c_next  = op_class[1] ? c_q : (op_class[0] ? sh_c : alu_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else if (flag_we) begin
      z_q <= z_next;
      c_q <= c_next;
    end
  end
endmodule

// File: rtl/byte_exec_unit_chk.sv
module byte_exec_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] op_class,
  input logic [2:0] func,
  input logic [7:0] src_a,
  input logic [7:0] src_b,
  input logic [2:0] shamt,
  input logic [7:0] result,
  input logic       z_next,
  input logic       c_next,
  input logic       flag_we,
  input logic       z_q,
  input logic       c_q
);
  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (z_next == (result == 8'h00)));

  a_r2_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 2'b00 && func == 3'b010) |-> (c_next == (src_a < src_b)));

  a_r3_logic_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 2'b00 && func[2]) |-> !c_next);

  a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 2'b01 && shamt == 3'd0) |-> (result == src_a && !c_next));

  a_r8_no_flag_class: assert property (@(posedge clk) disable iff (!rst_n)
    op_class[1] |-> (!flag_we && result == 8'h00 && z_next == z_q && c_next == c_q));

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(flag_we)) |-> (z_q == $past(z_next) && c_q == $past(c_next)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(flag_we)) |-> ($stable(z_q) && $stable(c_q)));
endmodule

bind byte_exec_unit byte_exec_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_class(op_class), .func(func),
  .src_a(src_a), .src_b(src_b), .shamt(shamt), .result(result),
  .z_next(z_next), .c_next(c_next), .flag_we(flag_we), .z_q(z_q), .c_q(c_q)
);

// File: tb/byte_exec_unit_tb_top.sv
module byte_exec_unit_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] op_class = 0;
  logic [2:0] func = 0;
  logic [7:0] src_a = 0, src_b = 0;
  logic [2:0] shamt = 0;
  logic c_in = 0;
  logic [7:0] result;
  logic z_next, c_next, flag_we, z_q, c_q;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  byte_exec_unit dut_i (.clk(clk), .rst_n(rst_n), .op_class(op_class), .func(func),
    .src_a(src_a), .src_b(src_b), .shamt(shamt), .c_in(c_in), .result(result),
    .z_next(z_next), .c_next(c_next), .flag_we(flag_we), .z_q(z_q), .c_q(c_q));

  // {class, func, a, b, count, cin, res, z, c} ; all rows have flag_we = 1
  localparam int NV = 26;
  localparam logic [34:0] VEC [NV] = '{
    {2'b00,3'b000,8'h3C,8'h14,3'd0,1'b0,8'h50,1'b0,1'b0}, // R1
    {2'b00,3'b000,8'hF0,8'h20,3'd0,1'b0,8'h10,1'b0,1'b1}, // R1
    {2'b00,3'b000,8'h80,8'h80,3'd0,1'b0,8'h00,1'b1,1'b1}, // R1 R4
    {2'b00,3'b001,8'h0F,8'h01,3'd0,1'b1,8'h11,1'b0,1'b0}, // R1
    {2'b00,3'b001,8'hFF,8'h00,3'd0,1'b1,8'h00,1'b1,1'b1}, // R1
    {2'b00,3'b010,8'h50,8'h20,3'd0,1'b0,8'h30,1'b0,1'b0}, // R2
    {2'b00,3'b010,8'h20,8'h50,3'd0,1'b0,8'hD0,1'b0,1'b1}, // R2
    {2'b00,3'b010,8'h44,8'h44,3'd0,1'b0,8'h00,1'b1,1'b0}, // R2
    {2'b00,3'b011,8'h10,8'h0F,3'd0,1'b1,8'h00,1'b1,1'b0}, // R2
    {2'b00,3'b011,8'h00,8'h00,3'd0,1'b1,8'hFF,1'b0,1'b1}, // R2
    {2'b00,3'b100,8'hF0,8'h3C,3'd0,1'b1,8'h30,1'b0,1'b0}, // R3
    {2'b00,3'b101,8'hA0,8'h05,3'd0,1'b1,8'hA5,1'b0,1'b0}, // R3
    {2'b00,3'b110,8'h5A,8'h5A,3'd0,1'b1,8'h00,1'b1,1'b0}, // R3
    {2'b00,3'b111,8'hF3,8'h30,3'd0,1'b1,8'hC3,1'b0,1'b0}, // R3
    {2'b00,3'b111,8'h0F,8'hFF,3'd0,1'b0,8'h00,1'b1,1'b0}, // R3
    {2'b01,3'b000,8'h81,8'h00,3'd1,1'b0,8'h02,1'b0,1'b1}, // R5
    {2'b01,3'b000,8'h0F,8'h00,3'd4,1'b1,8'hF0,1'b0,1'b0}, // R5
    {2'b01,3'b001,8'h81,8'h00,3'd1,1'b0,8'h40,1'b0,1'b1}, // R5
    {2'b01,3'b001,8'h80,8'h00,3'd7,1'b0,8'h01,1'b0,1'b0}, // R5
    {2'b01,3'b001,8'h40,8'h00,3'd7,1'b0,8'h00,1'b1,1'b1}, // R5
    {2'b01,3'b010,8'h81,8'h00,3'd1,1'b0,8'h03,1'b0,1'b1}, // R6
    {2'b01,3'b010,8'h12,8'h00,3'd4,1'b0,8'h21,1'b0,1'b1}, // R6
    {2'b01,3'b011,8'h01,8'h00,3'd1,1'b0,8'h80,1'b0,1'b1}, // R6
    {2'b01,3'b011,8'h34,8'h00,3'd3,1'b0,8'h86,1'b0,1'b1}, // R6
    {2'b01,3'b000,8'h00,8'h00,3'd0,1'b1,8'h00,1'b1,1'b0}, // R7
    {2'b01,3'b010,8'hA5,8'h00,3'd0,1'b1,8'hA5,1'b0,1'b0}  // R7
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] cl, input logic [2:0] fn, input logic [7:0] a,
                       input logic [7:0] b, input logic [2:0] sh, input logic ci);
    @(negedge clk);
    op_class = cl; func = fn; src_a = a; src_b = b; shamt = sh; c_in = ci;
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic hz, hc;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset", {z_q, c_q}, 2'b00);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      drive(v[34:33], v[32:30], v[29:22], v[21:14], v[13:11], v[10]);
      chk($sformatf("R1-6 vec%0d result", i), result, v[9:2]);
      chk($sformatf("R4 vec%0d flags", i), {z_next, c_next, flag_we}, {v[1], v[0], 1'b1});
      @(posedge clk); #1;
      chk($sformatf("R9 vec%0d held", i), {z_q, c_q}, v[1:0]);
    end

    // R1 R9 two-byte add chain: 0x01FF + 0x0001 = 0x0200
    drive(2'b00, 3'b000, 8'hFF, 8'h01, 3'd0, 1'b0);
    chk("R1 chain low", {c_next, result}, {1'b1, 8'h00});
    @(posedge clk); #1;
    chk("R9 chain carry held", c_q, 1'b1);
    drive(2'b00, 3'b001, 8'h01, 8'h00, 3'd0, c_q);
    chk("R1 chain high", {c_next, result}, {1'b0, 8'h02});
    @(posedge clk); #1;

    // R2 R9 two-byte subtract chain: 0x0100 - 0x0001 = 0x00FF
    drive(2'b00, 3'b010, 8'h00, 8'h01, 3'd0, 1'b0);
    chk("R2 chain low", {c_next, result}, {1'b1, 8'hFF});
    @(posedge clk); #1;
    drive(2'b00, 3'b011, 8'h01, 8'h00, 3'd0, c_q);
    chk("R2 chain high", {z_next, c_next, result}, {1'b1, 1'b0, 8'h00});
    @(posedge clk); #1;
    chk("R9 chain held", {z_q, c_q}, 2'b10);

    // set held flags to z=0 c=1 then check R8 classes leave them
    drive(2'b00, 3'b000, 8'hFF, 8'h02, 3'd0, 1'b0);
    @(posedge clk); #1;
    hz = z_q; hc = c_q;
    chk("R9 setup", {hz, hc}, 2'b01);
    for (int k = 2; k < 4; k++) begin
      drive(k[1:0], 3'b000, 8'h12, 8'h34, 3'd2, 1'b0);
      chk("R8 no update", {flag_we, result, z_next, c_next}, {1'b0, 8'h00, hz, hc});
      @(posedge clk); #1;
      chk("R8 R9 held kept", {z_q, c_q}, {hz, hc});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule